// File: doc/BRIEF.md
# Serial Display Command Receiver

This block takes command frames over a three-wire serial link (select, shift clock, data) and updates the stored state of a multiplexed display driver. A frame carries either a 32-bit segment pattern or a 10-bit brightness value, followed by a 3-bit mode field. The mode field arrives last, so the block cannot decode a frame until the frame has ended. When select falls, it decodes the mode and writes the payload into the register that the mode names. The target is one of three per-grid segment registers, all three together, or the brightness register.

The serial inputs are sampled in the system clock domain. They pass through two-flop synchronizers and edge detectors, so all state changes on the system clock. The serial clock must run at no more than a quarter of the system clock rate. A bit counter tracks each frame. The payload is always taken from the bits just before the final three, so the 13-bit brightness frame and the 35-bit segment frame share one shift register.

Top module: `disp_cmd_rx`

## Requirements
- R1: After reset, and again after any later reset, all three segment outputs and the brightness output read 0.
- R2: A bit is shifted in on a rising edge of the serial clock only while select is high. Clock edges while select is low leave no trace in the outputs or in the next frame.
- R3: In a segment frame, the first bit sent drives segment output bit 0 and the 32nd bit drives bit 31. A 1 means lit.
- R4: Mode m2m1m0 = 000, where m0 is the first mode bit sent, writes the same 32-bit pattern to all three segment outputs.
- R5: Mode 001 writes grid 1 only, 010 writes grid 2 only and 011 writes grid 3 only. The other two segment outputs and the brightness output keep their values.
- R6: Mode 100 writes the 10-bit brightness output from a 13-bit frame. The first bit sent is the LSB. No segment output changes.
- R7: Modes 101, 110 and 111 change no output.
- R8: A frame of fewer than 13 bits is discarded when select falls.
- R9: A frame longer than 35 bits is decoded from its last 35 bits only.
- R10: Outputs change only after select falls. While a frame is being shifted, every output holds its value.
- R11: In a segment frame of 13 to 34 bits, the received payload bits land on the highest segment bits. Segment bits that the frame did not supply are written as 0, because the shift register clears when select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Frame select, high while a frame is sent |
| sclk_i | input | 1 | Serial shift clock, bits taken on its rising edge |
| sdat_i | input | 1 | Serial data |
| seg_grid1_o | output | 32 | Segment pattern stored for grid 1 |
| seg_grid2_o | output | 32 | Segment pattern stored for grid 2 |
| seg_grid3_o | output | 32 | Segment pattern stored for grid 3 |
| bright_o | output | 10 | Stored brightness value |

## Verification
The bench sends frames of 12, 13, 35 and 38 bits. A design that counted bits wrongly would accept the 12-bit frame or shift the 38-bit frame's payload by the three leading bits. Clock pulses sent while select is low are followed by a short frame. A design that shifted without select, or that did not clear at the start of a frame, would put stray ones in the upper segment bits. The unused mode codes and the single-grid codes are each checked against the untouched registers, which catches a decoder that writes too widely. Outputs are also compared mid-frame, before select falls, to catch a design that writes early.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam int SEG_W    = 32;
    localparam int DIM_W    = 10;
    localparam int MODE_W   = 3;
    localparam int NUM_GRID = 3;
    localparam int SYNC_STG = 2;

    // mode codes, written m2m1m0 (m0 is the first mode bit on the wire)
    typedef enum logic [MODE_W-1:0] {
        MODE_ALL_GRIDS = 3'b000,
        MODE_GRID1     = 3'b001,
        MODE_GRID2     = 3'b010,
        MODE_GRID3     = 3'b011,
        MODE_BRIGHT    = 3'b100
    } mode_e;

    typedef struct packed {
        logic [NUM_GRID-1:0] grid_we;
        logic                dim_we;
    } wr_sel_t;

    function automatic wr_sel_t decode_mode(input logic [MODE_W-1:0] m);
        wr_sel_t s;
        s = '0;
        case (m)
            MODE_ALL_GRIDS: s.grid_we    = '1;
            MODE_GRID1:     s.grid_we[0] = 1'b1;
            MODE_GRID2:     s.grid_we[1] = 1'b1;
            MODE_GRID3:     s.grid_we[2] = 1'b1;
            MODE_BRIGHT:    s.dim_we     = 1'b1;
            default:        s            = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/disp_cmd_sync.sv
module disp_cmd_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/disp_cmd_shift.sv
module disp_cmd_shift #(
    parameter int SR_W    = 35,
    parameter int CNT_MIN = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_start,
    input  logic            shift_en,
    input  logic            din,
    output logic [SR_W-1:0] sr,
    output logic            cnt_ok
);
    localparam int CW = $clog2(CNT_MIN + 1);

    logic [CW-1:0]   cnt;
    logic [SR_W-1:0] sr_base;
    logic [CW-1:0]   cnt_base;

    // a new frame starts from an empty register
    assign sr_base  = frame_start ? '0 : sr;
    assign cnt_base = frame_start ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sr <= {sr_base[SR_W-2:0], din};
            if (cnt_base != CW'(CNT_MIN)) cnt <= cnt_base + 1'b1;
            else                          cnt <= cnt_base;
        end else begin
            sr  <= sr_base;
            cnt <= cnt_base;
        end
    end

    assign cnt_ok = (cnt == CW'(CNT_MIN));
endmodule

// File: rtl/disp_cmd_latch_bank.sv
module disp_cmd_latch_bank #(
    parameter int NG    = 3,
    parameter int SEG_W = 32,
    parameter int DIM_W = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NG-1:0]             grid_we,
    input  logic                      dim_we,
    input  logic [SEG_W-1:0]          seg_d,
    input  logic [DIM_W-1:0]          dim_d,
    output logic [NG-1:0][SEG_W-1:0]  seg_q,
    output logic [DIM_W-1:0]          dim_q
);
    for (genvar g = 0; g < NG; g++) begin : g_grid
        always_ff @(posedge clk) begin
            if (rst)             seg_q[g] <= '0;
            else if (grid_we[g]) seg_q[g] <= seg_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         dim_q <= '0;
        else if (dim_we) dim_q <= dim_d;
    end
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
    import disp_cmd_pkg::*;
#(
    parameter int SEG_BITS = SEG_W,
    parameter int DIM_BITS = DIM_W,
    parameter int STAGES   = SYNC_STG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_i,
    input  logic                sclk_i,
    input  logic                sdat_i,
    output logic [SEG_BITS-1:0] seg_grid1_o,
    output logic [SEG_BITS-1:0] seg_grid2_o,
    output logic [SEG_BITS-1:0] seg_grid3_o,
    output logic [DIM_BITS-1:0] bright_o
);
    localparam int SR_W    = SEG_BITS + MODE_W;
    localparam int MIN_LEN = DIM_BITS + MODE_W;

    logic [2:0]        lvl;
    logic [1:0]        lvl_d;
    logic              sel_rise, sel_fall, sclk_rise;
    logic [SR_W-1:0]   sr;
    logic              frame_ok;
    logic [MODE_W-1:0] mode;
    logic [SEG_BITS-1:0] seg_data;
    logic [DIM_BITS-1:0] dim_data;
    wr_sel_t           wr_sel;
    logic [NUM_GRID-1:0] wr_grid;
    logic              wr_dim;
    logic [NUM_GRID-1:0][SEG_BITS-1:0] seg_q;

    disp_cmd_sync #(.W(3), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({sel_i, sclk_i, sdat_i}),
        .lvl (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= '0;
        else     lvl_d <= lvl[2:1];
    end

    assign sel_rise  =  lvl[2] & ~lvl_d[1];
    assign sel_fall  = ~lvl[2] &  lvl_d[1];
    assign sclk_rise =  lvl[1] & ~lvl_d[0];

    disp_cmd_shift #(.SR_W(SR_W), .CNT_MIN(MIN_LEN)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .frame_start (sel_rise),
        .shift_en    (sclk_rise & lvl[2]),
        .din         (lvl[0]),
        .sr          (sr),
        .cnt_ok      (frame_ok)
    );

    // the last bit shifted sits in sr[0]; m0 came MODE_W-1 bits earlier
    for (genvar j = 0; j < MODE_W; j++) begin : g_mode
        assign mode[j] = sr[MODE_W-1-j];
    end
    for (genvar k = 0; k < SEG_BITS; k++) begin : g_seg
        assign seg_data[k] = sr[MODE_W+SEG_BITS-1-k];
    end
    for (genvar i = 0; i < DIM_BITS; i++) begin : g_dim
        assign dim_data[i] = sr[MODE_W+DIM_BITS-1-i];
    end

    assign wr_sel  = (sel_fall && frame_ok) ? decode_mode(mode) : '0;
    assign wr_grid = wr_sel.grid_we;
    assign wr_dim  = wr_sel.dim_we;

    disp_cmd_latch_bank #(.NG(NUM_GRID), .SEG_W(SEG_BITS), .DIM_W(DIM_BITS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .grid_we (wr_grid),
        .dim_we  (wr_dim),
        .seg_d   (seg_data),
        .dim_d   (dim_data),
        .seg_q   (seg_q),
        .dim_q   (bright_o)
    );

    assign seg_grid1_o = seg_q[0];
    assign seg_grid2_o = seg_q[1];
    assign seg_grid3_o = seg_q[2];
endmodule

// File: rtl/disp_cmd_rx_chk.sv
module disp_cmd_rx_chk #(
    parameter int SEG_BITS = 32,
    parameter int DIM_BITS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                sel_fall,
    input logic                frame_ok,
    input logic [2:0]          wr_grid,
    input logic                wr_dim,
    input logic [SEG_BITS-1:0] g1,
    input logic [SEG_BITS-1:0] g2,
    input logic [SEG_BITS-1:0] g3,
    input logic [DIM_BITS-1:0] dim
);
    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            p_reset_clear_r1: assert (g1 == '0 && g2 == '0 && g3 == '0 && dim == '0)
                else $error("outputs not cleared by reset");
        end
    end

    p_no_write_midframe_r10: assert property (@(posedge clk) disable iff (rst)
        !sel_fall |-> (wr_grid == 3'b000 && !wr_dim));

    p_short_frame_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_fall && !frame_ok) |-> (wr_grid == 3'b000 && !wr_dim));

    p_bright_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        wr_dim |-> (wr_grid == 3'b000));

    p_grid_targets_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_grid) != 2);

    p_broadcast_equal_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_grid == 3'b111) |=> (g1 == g2 && g2 == g3));

    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_grid == 3'b000 && !wr_dim) |=>
            ($stable(g1) && $stable(g2) && $stable(g3) && $stable(dim)));
endmodule

bind disp_cmd_rx disp_cmd_rx_chk #(.SEG_BITS(SEG_BITS), .DIM_BITS(DIM_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_fall (sel_fall),
    .frame_ok (frame_ok),
    .wr_grid  (wr_grid),
    .wr_dim   (wr_dim),
    .g1       (seg_grid1_o),
    .g2       (seg_grid2_o),
    .g3       (seg_grid3_o),
    .dim      (bright_o)
);

// File: tb/tb_disp_cmd_rx.sv
module tb_disp_cmd_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        sclk = 1'b0;
    logic        sdat = 1'b0;
    logic [31:0] g1, g2, g3;
    logic [9:0]  dim;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    logic [31:0] exp_seg [3];
    logic [9:0]  exp_dim;

    always #5 clk = ~clk;

    disp_cmd_rx dut (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (sel),
        .sclk_i      (sclk),
        .sdat_i      (sdat),
        .seg_grid1_o (g1),
        .seg_grid2_o (g2),
        .seg_grid3_o (g3),
        .bright_o    (dim)
    );

    // frame bits: bit 0 goes out first
    typedef struct packed {
        logic [5:0]  n;
        logic [39:0] bits;
        logic [3:0]  mask;   // [0..2] grids, [3] brightness
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{6'd35, 40'h00_A5C30F81, 4'b0111, 32'hA5C30F81, 4'd4},  // R4 broadcast
        '{6'd35, 40'h01_12345678, 4'b0001, 32'h12345678, 4'd5},  // R5 grid 1
        '{6'd35, 40'h02_FFFF0000, 4'b0010, 32'hFFFF0000, 4'd5},  // R5 grid 2
        '{6'd35, 40'h03_80000001, 4'b0100, 32'h80000001, 4'd3},  // R3 bit order, grid 3
        '{6'd13, 40'h00_000012C7, 4'b1000, 32'h000002C7, 4'd6},  // R6 brightness
        '{6'd35, 40'h05_DEADBEEF, 4'b0000, 32'h00000000, 4'd7},  // R7 code 101
        '{6'd13, 40'h00_00001FFF, 4'b0000, 32'h00000000, 4'd7},  // R7 code 111
        '{6'd35, 40'h06_13579BDF, 4'b0000, 32'h00000000, 4'd7},  // R7 code 110
        '{6'd38, 40'h08_787F8787, 4'b0001, 32'h0F0FF0F0, 4'd9},  // R9 long frame
        '{6'd13, 40'h00_00000BA5, 4'b0010, 32'hE9400000, 4'd11}, // R11 short segment frame
        '{6'd12, 40'h00_00000FFF, 4'b0000, 32'h00000000, 4'd8},  // R8 too short
        '{6'd13, 40'h00_000013FF, 4'b1000, 32'h000003FF, 4'd6}   // R6 full scale
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "grid1",  g1, exp_seg[0]);
        check(req, "grid2",  g2, exp_seg[1]);
        check(req, "grid3",  g3, exp_seg[2]);
        check(req, "bright", {22'd0, dim}, {22'd0, exp_dim});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [39:0] bits, input int n, input bit chk_mid);
        @(negedge clk);
        sel = 1'b1;
        wait_cyc(4);
        for (int i = 0; i < n; i++) begin
            sdat = bits[i];
            wait_cyc(4);
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
        end
        wait_cyc(4);
        if (chk_mid) check_all("R10");
        sel = 1'b0;
        wait_cyc(12);
    endtask

    task automatic apply(input logic [3:0] mask, input logic [31:0] val);
        for (int g = 0; g < 3; g++) if (mask[g]) exp_seg[g] = val;
        if (mask[3]) exp_dim = val[9:0];
    endtask

    task automatic clear_model();
        for (int g = 0; g < 3; g++) exp_seg[g] = '0;
        exp_dim = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        clear_model();
        wait_cyc(5);
        // R1: reset state
        check_all("R1");
        rst = 1'b0;
        wait_cyc(3);
        check_all("R1");

        // table walk
        for (int v = 0; v < NV; v++) begin
            send(VECS[v].bits, int'(VECS[v].n), 1'b1);
            apply(VECS[v].mask, VECS[v].val);
            check_all($sformatf("R%0d", VECS[v].req));
        end

        // R2: clock pulses with select low change nothing
        sdat = 1'b1;
        for (int i = 0; i < 40; i++) begin
            wait_cyc(4);
            sclk = 1'b1;
            wait_cyc(4);
            sclk = 1'b0;
        end
        wait_cyc(8);
        check_all("R2");

        // R8: select pulse with no bits is discarded
        send(40'h0, 0, 1'b0);
        check_all("R8");

        // R2 / R11: stray ones from idle pulses must not reach the next frame
        send(40'h00_00000D55, 13, 1'b0);
        apply(4'b0100, 32'h55400000);
        check_all("R2");

        // R1: reset after data has been loaded
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        clear_model();
        check_all("R1");
        rst = 1'b0;
        wait_cyc(2);

        // R4 after reset, broadcast again
        send(40'h00_0000FFFF, 35, 1'b0);
        apply(4'b0111, 32'h0000FFFF);
        check_all("R4");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule